// File: doc/BRIEF.md
# Paged Program Counter with Return-Address Stack

This block produces the 13-bit instruction fetch address for a small 8-bit microcontroller core. In each instruction cycle that is enabled, the address either steps forward by one or is replaced by a new target. A target can come from a jump or subroutine call, a return, a write to the low address byte, or an interrupt vector. Jump and call targets use an 11-bit literal for the low bits. The two page bits above it come from a separate page-latch register. A low-byte write takes its upper five bits from the same latch.

An eight-entry, 13-bit return stack holds the return addresses. It lives inside the block and is not part of program or data memory. Calls and interrupts push onto it. Returns pop from it. The stack is circular: when more than eight calls are nested, the oldest entry is overwritten and no error is raised. Whenever the address is redirected, a flush strobe tells the fetch stage to discard the instruction it has already fetched. A return-with-literal also asks the core to load its literal into the working register.

Top module: `pcu_top`

## Requirements
- R1: After reset the following hold: the fetch address is 0x0000, the stack depth is 0, flush is low and the working-register load strobe is low.
- R2: In a cycle where the enable is high and no redirect strobe is set, the address increments by one and wraps from 0x1FFF to 0x0000. When the enable is low, the address and the depth hold and all strobes are ignored.
- R3: A jump loads the address with {latch[4:3], lit[10:0]} and leaves the stack depth unchanged.
- R4: A call loads the same target as a jump. It pushes the current fetch address and raises the depth by one, saturating at 8.
- R5: A return loads the address with the most recently pushed entry and lowers the depth by one. It does not drop below 0.
- R6: An accepted interrupt pushes the current fetch address and loads 0x0004.
- R7: A return-with-literal behaves like a return. During that cycle it also drives the working-register load strobe high, with lit[7:0] on the working-register data output.
- R8: A low-byte write loads the address with {latch[4:0], wreg[7:0]}.
- R9: When several strobes are set in one cycle, the order of precedence is: interrupt, call, jump, return, return-with-literal, low-byte write. Only the winner takes effect.
- R10: The stack is circular. A ninth push overwrites the oldest entry. Eight pops then return the eight newest entries, newest first. A further pop wraps and returns the newest again, and the depth stays 0.
- R11: Flush is high, in the same cycle, exactly when the enable is high and any redirect strobe is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Instruction-cycle enable |
| irq_i | input | 1 | Take interrupt |
| call_i | input | 1 | Subroutine call |
| goto_i | input | 1 | Unconditional jump |
| ret_i | input | 1 | Return |
| retlw_i | input | 1 | Return with literal |
| pcl_wr_i | input | 1 | Write of the low address byte |
| lit_i | input | 11 | Instruction literal |
| wreg_i | input | 8 | Value written to the low address byte |
| plat_i | input | 8 | Page-latch register |
| pc_o | output | 13 | Fetch address |
| flush_o | output | 1 | Discard the prefetched instruction |
| wload_o | output | 1 | Load the working register |
| wdata_o | output | 8 | Literal for the working register |
| depth_o | output | 4 | Valid stack entries (0..8) |

## Verification
A table of mixed instruction patterns runs through the block. It places jumps to every page, calls into different pages, low-byte writes with differing latch values, an interrupt and two returns one after another. This shows whether page bits come from the right latch field, and whether the stack unwinds in order. Rows that set two strobes at once separate correct precedence from a wrong arbitration order. Directed sequences cover the rest: the address wrap, cycles with the enable low and strobes set, and nine nested calls followed by nine returns. The nested-call sequence separates a truly circular stack from one that saturates or stalls its pointer.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int PCU_PC_W  = 13;
  localparam int PCU_LIT_W = 11;
  localparam int PCU_DW    = 8;
  localparam int PCU_DEPTH = 8;

  typedef enum logic [2:0] {
    SEL_INC  = 3'd0,
    SEL_JMP  = 3'd1,
    SEL_RET  = 3'd2,
    SEL_PCL  = 3'd3,
    SEL_VEC  = 3'd4,
    SEL_HOLD = 3'd5
  } pc_sel_e;
endpackage

// File: rtl/pcu_arb.sv
module pcu_arb
  import pcu_pkg::*;
(
  input  logic    en_i,
  input  logic    irq_i,
  input  logic    call_i,
  input  logic    goto_i,
  input  logic    ret_i,
  input  logic    retlw_i,
  input  logic    pcl_wr_i,
  output pc_sel_e sel_o,
  output logic    push_o,
  output logic    pop_o,
  output logic    chg_o,
  output logic    wload_o
);
  always_comb begin
    sel_o   = SEL_INC;
    push_o  = 1'b0;
    pop_o   = 1'b0;
    wload_o = 1'b0;
    if (!en_i) begin
      sel_o = SEL_HOLD;
    end else if (irq_i) begin
      sel_o  = SEL_VEC;
      push_o = 1'b1;
    end else if (call_i) begin
      sel_o  = SEL_JMP;
      push_o = 1'b1;
    end else if (goto_i) begin
      sel_o = SEL_JMP;
    end else if (ret_i) begin
      sel_o = SEL_RET;
      pop_o = 1'b1;
    end else if (retlw_i) begin
      sel_o   = SEL_RET;
      pop_o   = 1'b1;
      wload_o = 1'b1;
    end else if (pcl_wr_i) begin
      sel_o = SEL_PCL;
    end
  end

  assign chg_o = (sel_o != SEL_INC) && (sel_o != SEL_HOLD);
endmodule

// File: rtl/pcu_stack.sv
module pcu_stack #(
  parameter int AW    = 13,
  parameter int DEPTH = 8,
  localparam int SP_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [AW-1:0]    din_i,
  output logic [AW-1:0]    top_o,
  output logic [CNT_W-1:0] depth_o
);
  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] sp_top;
  logic [AW-1:0]   slot_q [DEPTH];

  assign sp_top = sp_q - SP_W'(1);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   slot_q[g] <= '0;
      else if (push_i && (sp_q == SP_W'(g)))        slot_q[g] <= din_i;
    end
  end

  assign top_o = slot_q[sp_top];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= '0;
      depth_o <= '0;
    end else if (push_i) begin
      sp_q <= sp_q + SP_W'(1);
      if (depth_o != CNT_W'(DEPTH)) depth_o <= depth_o + CNT_W'(1);
    end else if (pop_i) begin
      sp_q <= sp_top;
      if (depth_o != '0) depth_o <= depth_o - CNT_W'(1);
    end
  end
endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg
  import pcu_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int LIT_W = 11,
  parameter int DW    = 8,
  parameter logic [PC_W-1:0] VEC = 13'h0004,
  localparam int PG_W  = PC_W - LIT_W,
  localparam int HI_W  = PC_W - DW,
  localparam int PG_LO = LIT_W - DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pc_sel_e          sel_i,
  input  logic [LIT_W-1:0] lit_i,
  input  logic [DW-1:0]    wreg_i,
  input  logic [DW-1:0]    plat_i,
  input  logic [PC_W-1:0]  ret_addr_i,
  output logic [PC_W-1:0]  pc_o
);
  function automatic logic [PC_W-1:0] jump_tgt(input logic [DW-1:0] lat,
                                               input logic [LIT_W-1:0] k);
    return {lat[PG_LO +: PG_W], k};
  endfunction

  function automatic logic [PC_W-1:0] pcl_tgt(input logic [DW-1:0] lat,
                                              input logic [DW-1:0] lo);
    return {lat[HI_W-1:0], lo};
  endfunction

  logic [PC_W-1:0] nxt;

  always_comb begin
    case (sel_i)
      SEL_JMP:  nxt = jump_tgt(plat_i, lit_i);
      SEL_RET:  nxt = ret_addr_i;
      SEL_PCL:  nxt = pcl_tgt(plat_i, wreg_i);
      SEL_VEC:  nxt = VEC;
      SEL_HOLD: nxt = pc_o;
      default:  nxt = pc_o + PC_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_o <= '0;
    else        pc_o <= nxt;
  end
endmodule

// File: rtl/pcu_top.sv
module pcu_top
  import pcu_pkg::*;
#(
  parameter int PC_W  = PCU_PC_W,
  parameter int LIT_W = PCU_LIT_W,
  parameter int DW    = PCU_DW,
  parameter int DEPTH = PCU_DEPTH,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             irq_i,
  input  logic             call_i,
  input  logic             goto_i,
  input  logic             ret_i,
  input  logic             retlw_i,
  input  logic             pcl_wr_i,
  input  logic [LIT_W-1:0] lit_i,
  input  logic [DW-1:0]    wreg_i,
  input  logic [DW-1:0]    plat_i,
  output logic [PC_W-1:0]  pc_o,
  output logic             flush_o,
  output logic             wload_o,
  output logic [DW-1:0]    wdata_o,
  output logic [CNT_W-1:0] depth_o
);
  pc_sel_e         sel;
  logic            push_ev;
  logic            pop_ev;
  logic            chg_ev;
  logic [PC_W-1:0] stk_top;

  pcu_arb u_arb (
    .en_i(en_i), .irq_i(irq_i), .call_i(call_i), .goto_i(goto_i),
    .ret_i(ret_i), .retlw_i(retlw_i), .pcl_wr_i(pcl_wr_i),
    .sel_o(sel), .push_o(push_ev), .pop_o(pop_ev), .chg_o(chg_ev),
    .wload_o(wload_o)
  );

  pcu_stack #(.AW(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_i(push_ev), .pop_i(pop_ev),
    .din_i(pc_o), .top_o(stk_top), .depth_o(depth_o)
  );

  pcu_pc_reg #(.PC_W(PC_W), .LIT_W(LIT_W), .DW(DW)) u_pc (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .lit_i(lit_i), .wreg_i(wreg_i),
    .plat_i(plat_i), .ret_addr_i(stk_top), .pc_o(pc_o)
  );

  assign flush_o = chg_ev;
  assign wdata_o = lit_i[DW-1:0];
endmodule

// File: rtl/pcu_chk.sv
module pcu_chk #(
  parameter int PC_W  = 13,
  parameter int CNT_W = 4,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             irq_i,
  input logic             call_i,
  input logic             push_ev,
  input logic             pop_ev,
  input logic             chg_ev,
  input logic             flush_o,
  input logic [PC_W-1:0]  pc_o,
  input logic [CNT_W-1:0] depth_o
);
  // R2
  seq_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !chg_ev) |=> (pc_o == $past(pc_o) + PC_W'(1)));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(pc_o) && $stable(depth_o)));
  // R6
  irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && irq_i) |=> (pc_o == PC_W'(4)));
  // R4
  push_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ev && depth_o != CNT_W'(DEPTH)) |=> (depth_o == $past(depth_o) + CNT_W'(1)));
  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= CNT_W'(DEPTH));
  // R11
  flush_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> en_i);
  // R9
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_ev && pop_ev));
  // R4
  call_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && call_i) |-> push_ev);
endmodule

bind pcu_top pcu_chk #(.PC_W(PC_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .irq_i(irq_i), .call_i(call_i),
  .push_ev(push_ev), .pop_ev(pop_ev), .chg_ev(chg_ev), .flush_o(flush_o),
  .pc_o(pc_o), .depth_o(depth_o)
);

// File: tb/pcu_top_test.sv
module pcu_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0;
  logic        irq_i = 1'b0, call_i = 1'b0, goto_i = 1'b0;
  logic        ret_i = 1'b0, retlw_i = 1'b0, pcl_wr_i = 1'b0;
  logic [10:0] lit_i = '0;
  logic [7:0]  wreg_i = '0, plat_i = '0;
  logic [12:0] pc_o;
  logic        flush_o, wload_o;
  logic [7:0]  wdata_o;
  logic [3:0]  depth_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pcu_top uut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .irq_i(irq_i), .call_i(call_i),
    .goto_i(goto_i), .ret_i(ret_i), .retlw_i(retlw_i), .pcl_wr_i(pcl_wr_i),
    .lit_i(lit_i), .wreg_i(wreg_i), .plat_i(plat_i), .pc_o(pc_o),
    .flush_o(flush_o), .wload_o(wload_o), .wdata_o(wdata_o), .depth_o(depth_o)
  );

  // ctrl = {irq, call, goto, ret, retlw, pclwr}, lit, wreg, latch, exp pc, exp depth
  localparam int NV = 10;
  localparam logic [49:0] TBL [NV] = '{
    {6'b000000, 11'h000, 8'h00, 8'h00, 13'h0001, 4'd0},
    {6'b001000, 11'h123, 8'h00, 8'h18, 13'h1923, 4'd0},
    {6'b010000, 11'h045, 8'h00, 8'h08, 13'h0845, 4'd1},
    {6'b000000, 11'h000, 8'h00, 8'h00, 13'h0846, 4'd1},
    {6'b000001, 11'h000, 8'h9A, 8'h15, 13'h159A, 4'd1},
    {6'b110000, 11'h3FF, 8'h00, 8'h18, 13'h0004, 4'd2},
    {6'b000010, 11'h07E, 8'h00, 8'h00, 13'h159A, 4'd1},
    {6'b000100, 11'h000, 8'h00, 8'h00, 13'h1923, 4'd0},
    {6'b001100, 11'h7FF, 8'h00, 8'h00, 13'h07FF, 4'd0},
    {6'b000000, 11'h000, 8'h00, 8'h00, 13'h0800, 4'd0}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] c, input logic [10:0] k,
                       input logic [7:0] w, input logic [7:0] l);
    {irq_i, call_i, goto_i, ret_i, retlw_i, pcl_wr_i} = c;
    lit_i = k; wreg_i = w; plat_i = l;
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #40000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pc_o == 13'h0, "R1 pc", pc_o, 0);
    chk(depth_o == 4'd0, "R1 depth", depth_o, 0);
    chk(flush_o == 1'b0, "R1 flush", flush_o, 0);
    chk(wload_o == 1'b0, "R1 wload", wload_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    en_i = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [5:0] c;
      logic [10:0] k;
      logic e_wl;
      c = TBL[i][49:44];
      k = TBL[i][43:33];
      drive(c, k, TBL[i][32:25], TBL[i][24:17]);
      e_wl = c[1] && !(|c[5:2]);
      #1;
      // R11 flush with any redirect, R7 literal load
      chk(flush_o == (c != 6'b0), "R11 flush", flush_o, (c != 6'b0));
      chk(wload_o == e_wl, "R7 wload", wload_o, e_wl);
      if (e_wl) chk(wdata_o == k[7:0], "R7 wdata", wdata_o, k[7:0]);
      tick();
      // R3 R4 R5 R6 R8 R9 target and depth per row
      chk(pc_o == TBL[i][16:4], "R3/R4/R5/R6/R8/R9 pc", pc_o, TBL[i][16:4]);
      chk(depth_o == TBL[i][3:0], "R4/R5 depth", depth_o, TBL[i][3:0]);
    end

    // R2 wrap: R8 write to 0x1FFF, then increment
    drive(6'b000001, 11'h0, 8'hFF, 8'h1F);
    tick();
    chk(pc_o == 13'h1FFF, "R8 pcl", pc_o, 13'h1FFF);
    drive(6'b000000, 11'h0, 8'h00, 8'h00);
    tick();
    chk(pc_o == 13'h0000, "R2 wrap", pc_o, 0);

    // R2 enable low ignores strobes
    en_i = 1'b0;
    drive(6'b110000, 11'h555, 8'h00, 8'h18);
    #1;
    chk(flush_o == 1'b0, "R2 flush hold", flush_o, 0);
    tick();
    chk(pc_o == 13'h0000, "R2 pc hold", pc_o, 0);
    chk(depth_o == 4'd0, "R2 depth hold", depth_o, 0);
    en_i = 1'b1;

    // R10 circular: nine calls then nine returns
    for (int i = 1; i <= 9; i++) begin
      drive(6'b010000, 11'(i * 16), 8'h00, 8'h00);
      tick();
      chk(pc_o == 13'(i * 16), "R4 call pc", pc_o, i * 16);
    end
    chk(depth_o == 4'd8, "R10 saturate", depth_o, 8);
    for (int j = 1; j <= 8; j++) begin
      drive(6'b000100, 11'h0, 8'h00, 8'h00);
      tick();
      chk(pc_o == 13'((9 - j) * 16), "R10 pop order", pc_o, (9 - j) * 16);
    end
    chk(depth_o == 4'd0, "R5 depth zero", depth_o, 0);
    drive(6'b000100, 11'h0, 8'h00, 8'h00);
    tick();
    chk(pc_o == 13'h0080, "R10 wrap pop", pc_o, 13'h80);
    chk(depth_o == 4'd0, "R5 floor", depth_o, 0);
    drive(6'b000000, 11'h0, 8'h00, 8'h00);
    tick();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule